// File: doc/BRIEF.md
# Residue-Quotient Guarded SAD Element

This block wraps a single sum-of-absolute-difference processing element, of the kind chained in a systolic motion-estimation array, with concurrent error detection and data recovery. Pixel pairs (current and reference, 8 bits each) stream in over a valid/ready channel. The element accumulates the absolute difference of each pair into a 12-bit SAD. Beside it, a code generator tracks the same sum in a separate form: a residue modulo 64 and a quotient by 64. It builds both with plain adders, and a carry out of the residue feeds the quotient.

When a block of `NPIX` pairs (16, a 4x4 block) completes, a checker derives the residue and quotient of the element's actual output and compares them with the generated codes. On any mismatch it raises the error flag, and the output multiplexer forwards the value rebuilt as quotient·64 + residue in place of the element's own result. Detection and recovery happen in the same cycle as the result is presented. A `fault_mask` input XORs onto the element's accumulator output so that a bench can inject faults.

The result leaves on a valid/ready channel. The result is held, unchanged, until `out_ready` is high. While a result is held, `in_ready` is low and no pixel pair is accepted. This back-pressure stops the next block until the current result has been taken.

Top module: `rq_sad_guard`

## Requirements
- R1: After reset, `out_valid` is 0, `out_err` is 0 and `in_ready` is 1.
- R2: After `NPIX` accepted pairs, `out_valid` rises in the cycle that follows the last accepting clock edge. With no fault, `out_data` then equals the sum of |cur − ref| over those pairs.
- R3: A pair accepted with `in_first` = 1 discards any partial sum and becomes pair 1 of a new block. After a block completes, the next accepted pair starts a new block even without `in_first`.
- R4: The code generator holds the SAD as residue = SAD mod 64 and quotient = SAD div 64. The recovered value is quotient·64 + residue.
- R5: With `fault_mask` = 0, `out_err` is 0 while `out_valid` is 1, and `out_data` is the element's own SAD.
- R6: With any nonzero `fault_mask`, `out_err` is 1 while `out_valid` is 1, and `out_data` still equals the true SAD.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_data` and `out_err` hold, and `in_ready` is 0. The result is released at the first edge with `out_ready` = 1.
- R8: Cycles with `in_valid` = 0 between pairs do not change the sum. Pairs offered while `in_ready` = 0 are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Pixel pair can be accepted |
| in_first | input | 1 | Offered pair starts a new block |
| in_cur | input | 8 | Current-frame pixel |
| in_ref | input | 8 | Reference-frame pixel |
| fault_mask | input | 12 | XOR mask on the element's accumulator output (fault injection) |
| out_valid | output | 1 | Block result presented |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 12 | Selected SAD: own result or recovered value |
| out_err | output | 1 | Codes disagreed with the element's output |

## Verification
The assertions assume that `fault_mask` is steady while a result is presented. They also assume that an injected mask touches only the element's output, never the code registers, since the flag and the recovered value are judged against those registers. The stimulus sets the mask before each block and changes it only after the result has been taken. It covers every single-bit mask, several multi-bit masks and the all-ones mask, against zero, maximum, reversed, ramp and pseudo-random pixel patterns. The stimulus also inserts idle cycles between pairs, offers pairs during output stalls, and restarts a block midway.

// File: rtl/rq_sad_pkg.sv
package rq_sad_pkg;
  localparam int DEF_PIX_W = 8;
  localparam int DEF_NPIX  = 16;
  localparam int DEF_RES_W = 6;

  function automatic int sad_width(input int pix_w, input int npix);
    return $clog2(npix * ((1 << pix_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/sad_accum.sv
module sad_accum #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] refp,
  output logic [SAD_W-1:0] sad
);
  logic [PIX_W-1:0] diff;

  always_comb diff = (cur >= refp) ? (cur - refp) : (refp - cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sad <= '0;
    else if (take) begin
      if (restart)    sad <= SAD_W'(diff);
      else            sad <= sad + SAD_W'(diff);
    end
  end
endmodule

// File: rtl/rq_code_gen.sv
module rq_code_gen #(
  parameter int PIX_W = 8,
  parameter int RES_W = 6,
  parameter int QUO_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic [PIX_W-1:0] cur,
  input  logic [PIX_W-1:0] refp,
  output logic [RES_W-1:0] res,
  output logic [QUO_W-1:0] quo
);
  localparam int DQ_W = PIX_W - RES_W;

  logic [PIX_W-1:0] diff;
  logic [RES_W-1:0] d_res;
  logic [DQ_W-1:0]  d_quo;
  logic [RES_W:0]   res_sum;

  always_comb begin
    diff    = (cur >= refp) ? (cur - refp) : (refp - cur);
    d_res   = diff[RES_W-1:0];
    d_quo   = diff[PIX_W-1:RES_W];
    res_sum = {1'b0, res} + {1'b0, d_res};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0;
      quo <= '0;
    end else if (take) begin
      if (restart) begin
        res <= d_res;
        quo <= QUO_W'(d_quo);
      end else begin
        res <= res_sum[RES_W-1:0];
        quo <= quo + QUO_W'(d_quo) + QUO_W'(res_sum[RES_W]);
      end
    end
  end

  // R4
  residue_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !restart |=> res == RES_W'($past(res) + $past(d_res)));
endmodule

// File: rtl/rq_check_recover.sv
module rq_check_recover #(
  parameter int SAD_W = 12,
  parameter int RES_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SAD_W-1:0]       pe_sad,
  input  logic [RES_W-1:0]       gen_res,
  input  logic [SAD_W-RES_W-1:0] gen_quo,
  output logic                   err,
  output logic [SAD_W-1:0]       sel_sad
);
  localparam int QUO_W = SAD_W - RES_W;

  logic [RES_W-1:0] act_res;
  logic [QUO_W-1:0] act_quo;
  logic [SAD_W-1:0] rebuilt;

  always_comb begin
    act_res = pe_sad[RES_W-1:0];
    act_quo = pe_sad[SAD_W-1:RES_W];
    err     = (act_res != gen_res) || (act_quo != gen_quo);
    rebuilt = (SAD_W'(gen_quo) << RES_W) + SAD_W'(gen_res);
    sel_sad = err ? rebuilt : pe_sad;
  end

  // R6
  recover_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_sad == {gen_quo, gen_res});
endmodule

// File: rtl/rq_sad_guard.sv
module rq_sad_guard
  import rq_sad_pkg::*;
#(
  parameter int PIX_W = DEF_PIX_W,
  parameter int NPIX  = DEF_NPIX,
  parameter int RES_W = DEF_RES_W,
  parameter int SAD_W = sad_width(DEF_PIX_W, DEF_NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_first,
  input  logic [PIX_W-1:0] in_cur,
  input  logic [PIX_W-1:0] in_ref,
  input  logic [SAD_W-1:0] fault_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SAD_W-1:0] out_data,
  output logic             out_err
);
  localparam int QUO_W = SAD_W - RES_W;
  localparam int CNT_W = $clog2(NPIX + 1);

  logic             take, restart, last;
  logic [CNT_W-1:0] cnt;
  logic [SAD_W-1:0] pe_sad, pe_faulty;
  logic [RES_W-1:0] gen_res;
  logic [QUO_W-1:0] gen_quo;
  logic             chk_err;

  assign in_ready = !out_valid;
  assign take     = in_valid && in_ready;
  assign restart  = in_first || (cnt == '0);
  assign last     = take && (restart ? (NPIX == 1) : (cnt == CNT_W'(NPIX - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (take) begin
      if (last)         cnt <= '0;
      else if (restart) cnt <= CNT_W'(1);
      else              cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_valid <= 1'b0;
    else if (last)                   out_valid <= 1'b1;
    else if (out_valid && out_ready) out_valid <= 1'b0;
  end

  sad_accum #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(restart),
    .cur(in_cur), .refp(in_ref), .sad(pe_sad));

  rq_code_gen #(.PIX_W(PIX_W), .RES_W(RES_W), .QUO_W(QUO_W)) u_gen (
    .clk(clk), .rst_n(rst_n), .take(take), .restart(restart),
    .cur(in_cur), .refp(in_ref), .res(gen_res), .quo(gen_quo));

  assign pe_faulty = pe_sad ^ fault_mask;

  rq_check_recover #(.SAD_W(SAD_W), .RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pe_sad(pe_faulty), .gen_res(gen_res),
    .gen_quo(gen_quo), .err(chk_err), .sel_sad(out_data));

  assign out_err = out_valid && chk_err;

  // R2
  done_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(take));
  // R5
  clean_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (fault_mask == '0) |-> !out_err && (out_data == pe_sad));
  // R6
  fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (fault_mask != '0) |-> out_err && (out_data == pe_sad));
  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(pe_sad) && !take);
endmodule

// File: tb/rq_sad_guard_tb.sv
module rq_sad_guard_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, in_valid, in_ready, in_first, out_valid, out_ready, out_err;
  logic [7:0]  in_cur, in_ref;
  logic [11:0] fault_mask, out_data;
  int n_run = 0, n_fail = 0;
  bit finished = 0;
  int unsigned lcg = 32'h1234_5678;

  rq_sad_guard u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 16;
  endfunction

  task automatic send(input int c, input int r, input bit first, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); in_valid = 0; in_cur = 8'(rnd()); in_ref = 8'(rnd());
    end
    @(negedge clk);
    in_valid = 1; in_first = first; in_cur = 8'(c); in_ref = 8'(r);
    @(posedge clk);
  endtask

  task automatic run_block(input int pat, input logic [11:0] mask, input bit gaps,
                           input int stall);
    int exp = 0;
    int c, r;
    fault_mask = mask;
    for (int i = 0; i < 16; i++) begin
      case (pat)
        0: begin c = 77; r = 77; end
        1: begin c = 255; r = 0; end
        2: begin c = 0; r = 255; end
        3: begin c = i * 16; r = 255 - i * 7; end
        default: begin c = rnd() & 255; r = rnd() & 255; end
      endcase
      exp += (c > r) ? c - r : r - c;
      send(c, r, i == 0, gaps ? int'(rnd() % 3) : 0);
    end
    @(negedge clk);
    in_valid = 0; in_first = 0;
    chk(out_valid == 1, "R2 valid", out_valid, 1);
    if (mask == 0) begin
      chk(out_data == 12'(exp), "R5 data", out_data, exp);
      chk(out_err == 0, "R5 flag", out_err, 0);
    end else begin
      chk(out_data == 12'(exp), "R6 recovered", out_data, exp);
      chk(out_err == 1, "R6 flag", out_err, 1);
    end
    for (int s = 0; s < stall; s++) begin
      in_valid = 1; in_cur = 8'(rnd()); in_ref = 8'(rnd());
      @(negedge clk);
      chk(out_valid && out_data == 12'(exp), "R7 hold", out_data, exp);
      chk(in_ready == 0, "R7 in_ready", in_ready, 0);
    end
    in_valid = 0;
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    chk(out_valid == 0, "R7 release", out_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_first = 0; in_cur = 0; in_ref = 0;
    fault_mask = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_err == 0 && in_ready == 1, "R1 reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1, "R1 ready", in_ready, 1);

    for (int p = 0; p < 6; p++) run_block(p, 12'h000, p[0], 0);
    for (int b = 0; b < 12; b++) run_block(b % 6, 12'(1 << b), b[1], b % 3);
    run_block(1, 12'hFFF, 1, 2);
    run_block(4, 12'hA5A, 0, 1);
    run_block(3, 12'h801, 1, 0);
    // R8: random gaps with clean mask
    for (int k = 0; k < 20; k++) run_block(4, 12'h000, 1, k % 4);

    // R3: partial block abandoned by in_first
    fault_mask = 0;
    for (int i = 0; i < 5; i++) send(200, 3, i == 0, 0);
    run_block(3, 12'h000, 0, 0);
    for (int i = 0; i < 7; i++) send(9, 250, i == 0, 1);
    run_block(1, 12'h040, 1, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule